// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Lock Indication and Divider Reset Control

This block compares two divider outputs in a synchronous clock domain. One is the reference-side pulse train and the other is the feedback-side pulse train. A rising edge on the reference input arms a pump-up flag, and a rising edge on the feedback input arms a pump-down flag. Once both flags are set, a short fixed delay runs and then clears both flags together.

The edge that arrives first therefore holds its pump active for the phase lead plus the minimum width. The edge that arrives second produces a pulse of exactly the minimum width. A second leading edge that arrives before the trailing one is absorbed, so the detector keeps pumping in the same direction. This gives the full plus/minus one-cycle detection range and frequency steering. The drive-enable output marks when the external charge pump should leave high impedance.

Every clear of the two flags is a comparison. A comparison whose one-sided interval is within tolerance counts toward lock. A run of consecutive good comparisons declares lock. The lock-detect output stays high when the loop is locked or the pumps are idle, and drops low while the pumps are active and the loop is not locked.

A divider-reset request holds both the reference and feedback counters in clear and quiets the detector. Both counters are released on the same clock, so the feedback count restarts aligned with the reference count.

Top module: `pfd_lock_top`

## Requirements
- R1: After the asynchronous reset (rst_n low) is released, pump_up, pump_dn, pump_oe, r_cnt_clr and n_cnt_clr are 0 and lock_det is 1.
- R2: A rising edge on ref_pulse, sampled at a clock edge, sets pump_up from that edge onward. A rising edge on div_pulse does the same for pump_dn.
- R3: Once pump_up and pump_dn are both 1, both return to 0 after exactly MIN_W (default 2) clocks. The leading pump is therefore high for (edge separation + MIN_W) clocks and the trailing pump for MIN_W clocks. Coincident edges give both pumps exactly MIN_W clocks.
- R4: A pump falls only on a clock where the other pump was also high. Further edges of the leading input, before the trailing edge arrives, keep the leading pump high with no break.
- R5: pump_oe is 1 exactly on the cycles in which pump_up or pump_dn is 1, and is 0 (high impedance) otherwise.
- R6: Lock is declared at the end of the LOCK_CNT-th (default 4) consecutive comparison whose one-sided interval is at most LOCK_TOL (default 0) clocks. Any comparison above that tolerance clears lock and the run.
- R7: lock_det is 1 whenever lock is declared or both pumps are 0. It is 0 on cycles where a pump is active and lock is not declared.
- R8: r_cnt_clr and n_cnt_clr both rise one clock after cnt_rst_req rises, and both fall on the same clock, one clock after cnt_rst_req falls.
- R9: While the divider-reset request is held, both pumps stay 0 and input edges are ignored. The run of good comparisons is cleared, so lock must be reacquired after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Reference divider output |
| div_pulse | input | 1 | Feedback divider output |
| cnt_rst_req | input | 1 | Divider-reset request, active high |
| pump_up | output | 1 | Pump-up command |
| pump_dn | output | 1 | Pump-down command |
| pump_oe | output | 1 | Charge pump drive enable (0 = high impedance) |
| lock_det | output | 1 | Lock indication, low pulses while unlocked |
| r_cnt_clr | output | 1 | Hold reference counter in clear |
| n_cnt_clr | output | 1 | Hold feedback counter in clear |

## Verification
The properties assume that the inputs are synchronous to clk and change away from its rising edge. They also assume that each divider pulse falls again before it can rise anew, so every edge is seen once. The bench drives ref_pulse and div_pulse as one-clock pulses on falling clock edges and holds cnt_rst_req stable for several clocks at a time. It sweeps every signed edge separation across a small range, repeats coincident comparisons to cross the lock threshold, and injects a second leading edge inside a pending comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // good comparison: one-sided interval within tolerance
  function automatic logic skew_ok(input int skew, input int tol);
    return (skew <= tol);
  endfunction

  // saturating run counter update
  function automatic int next_run(input int run, input logic good, input int lim);
    if (!good) return 0;
    if (run >= lim) return lim;
    return run + 1;
  endfunction

  // saturating increment of a skew count
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int MIN_W = 2,
  parameter int SKW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           up_ev,
  input  logic           dn_ev,
  output logic           up,
  output logic           dn,
  output logic           cmp_ev,
  output logic [SKW-1:0] cmp_skew
);
  localparam int AW      = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam int SKW_MAX = (1 << SKW) - 1;

  logic [AW-1:0]  and_cnt;
  logic [SKW-1:0] skew;
  logic           both;
  logic           clr;

  assign both     = up & dn;
  assign clr      = both & (int'(and_cnt) == MIN_W - 1);
  assign cmp_ev   = clr;
  assign cmp_skew = skew;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up      <= 1'b0;
      dn      <= 1'b0;
      and_cnt <= '0;
      skew    <= '0;
    end else if (hold) begin
      up      <= 1'b0;
      dn      <= 1'b0;
      and_cnt <= '0;
      skew    <= '0;
    end else begin
      up      <= (up & ~clr) | up_ev;
      dn      <= (dn & ~clr) | dn_ev;
      and_cnt <= (both & ~clr) ? and_cnt + 1'b1 : '0;
      if (clr)
        skew <= '0;
      else if (up ^ dn)
        skew <= SKW'(pfd_pkg::sat_inc(int'(skew), SKW_MAX));
    end
  end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int LOCK_CNT = 4,
  parameter int LOCK_TOL = 0,
  parameter int SKW      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           cmp_ev,
  input  logic [SKW-1:0] cmp_skew,
  output logic           locked
);
  localparam int RW = $clog2(LOCK_CNT + 1);

  logic [RW-1:0] run;
  logic          good;

  assign good   = pfd_pkg::skew_ok(int'(cmp_skew), LOCK_TOL);
  assign locked = (int'(run) >= LOCK_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= '0;
    else if (hold)   run <= '0;
    else if (cmp_ev) run <= RW'(pfd_pkg::next_run(int'(run), good, LOCK_CNT));
  end
endmodule

// File: rtl/pfd_rst_ctl.sv
module pfd_rst_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic r_clr,
  output logic n_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_clr <= 1'b0;
      n_clr <= 1'b0;
    end else begin
      r_clr <= req;
      n_clr <= req;
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int MIN_W    = 2,
  parameter int LOCK_CNT = 4,
  parameter int LOCK_TOL = 0,
  parameter int SKW      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic div_pulse,
  input  logic cnt_rst_req,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe,
  output logic lock_det,
  output logic r_cnt_clr,
  output logic n_cnt_clr
);
  localparam int NIN = 2;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] rise_w;
  logic           cmp_ev_w;
  logic [SKW-1:0] cmp_skew_w;
  logic           locked_w;

  assign raw_in = {div_pulse, ref_pulse};

  for (genvar g = 0; g < NIN; g++) begin : g_edge
    pfd_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .rise (rise_w[g])
    );
  end

  pfd_core #(.MIN_W(MIN_W), .SKW(SKW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (cnt_rst_req),
    .up_ev   (rise_w[0]),
    .dn_ev   (rise_w[1]),
    .up      (pump_up),
    .dn      (pump_dn),
    .cmp_ev  (cmp_ev_w),
    .cmp_skew(cmp_skew_w)
  );

  pfd_lock_mon #(.LOCK_CNT(LOCK_CNT), .LOCK_TOL(LOCK_TOL), .SKW(SKW)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (cnt_rst_req),
    .cmp_ev  (cmp_ev_w),
    .cmp_skew(cmp_skew_w),
    .locked  (locked_w)
  );

  pfd_rst_ctl u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (cnt_rst_req),
    .r_clr(r_cnt_clr),
    .n_clr(n_cnt_clr)
  );

  assign pump_oe  = pump_up | pump_dn;
  assign lock_det = locked_w | ~pump_oe;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic cnt_rst_req,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_oe,
  input logic lock_det,
  input logic r_cnt_clr,
  input logic n_cnt_clr,
  input logic locked,
  input logic cmp_ev
);
  // R4
  up_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_up) |-> $past(pump_dn));

  // R4
  dn_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_dn) |-> $past(pump_up));

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_oe |-> (!pump_up && !pump_dn));

  // R7
  lockdet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_det |-> (pump_oe && !locked));

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_ev));

  // R8
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_req |=> (r_cnt_clr && n_cnt_clr));

  // R8
  release_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_cnt_clr) |-> $fell(n_cnt_clr));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt_clr |-> (!pump_up && !pump_dn));
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_rst_req(cnt_rst_req),
  .pump_up    (pump_up),
  .pump_dn    (pump_dn),
  .pump_oe    (pump_oe),
  .lock_det   (lock_det),
  .r_cnt_clr  (r_cnt_clr),
  .n_cnt_clr  (n_cnt_clr),
  .locked     (locked_w),
  .cmp_ev     (cmp_ev_w)
);

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;
  localparam int CLK_P    = 10;
  localparam int MIN_W    = 2;
  localparam int LOCK_CNT = 4;
  localparam int LOCK_TOL = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0, div_pulse = 1'b0, cnt_rst_req = 1'b0;
  logic pump_up, pump_dn, pump_oe, lock_det, r_cnt_clr, n_cnt_clr;

  int checks = 0;
  int errors = 0;
  int run_m  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pfd_lock_top #(.MIN_W(MIN_W), .LOCK_CNT(LOCK_CNT), .LOCK_TOL(LOCK_TOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
    .cnt_rst_req(cnt_rst_req), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_oe(pump_oe), .lock_det(lock_det), .r_cnt_clr(r_cnt_clr), .n_cnt_clr(n_cnt_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // fa: reference edge slot, fa2: extra reference edge slot (-1 none), fb: feedback edge slot
  task automatic compare(input int fa, input int fa2, input int fb);
    int first   = (fa < fb) ? fa : fb;
    int last    = (fa < fb) ? fb : fa;
    int skew    = last - first;
    int up_exp  = (fb - fa > 0 ? fb - fa : 0) + MIN_W;
    int dn_exp  = (fa - fb > 0 ? fa - fb : 0) + MIN_W;
    bit lk      = (run_m >= LOCK_CNT);
    int win     = last + MIN_W + 3;
    int up_w    = 0;
    int dn_w    = 0;
    bit up_gap  = 1'b0;
    bit up_seen = 1'b0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pump_up) begin
        up_w++;
        if (up_gap) up_seen = 1'b1;
      end else if (up_w > 0) up_gap = 1'b1;
      if (pump_dn) dn_w++;
      chk("R5 oe", int'(pump_oe), int'(pump_up | pump_dn));
      chk("R7 lock_det", int'(lock_det), (pump_up | pump_dn) ? int'(lk) : 1);
      ref_pulse = (i == fa) || (i == fa2);
      div_pulse = (i == fb);
    end
    ref_pulse = 1'b0;
    div_pulse = 1'b0;
    chk("R3 up width", up_w, up_exp);
    chk("R3 dn width", dn_w, dn_exp);
    if (fa2 >= 0) chk("R4 up unbroken", int'(up_seen), 0);
    run_m = (skew <= LOCK_TOL) ? ((run_m >= LOCK_CNT) ? LOCK_CNT : run_m + 1) : 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 up", int'(pump_up), 0);
    chk("R1 dn", int'(pump_dn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 up", int'(pump_up), 0);
    chk("R1 dn", int'(pump_dn), 0);
    chk("R1 oe", int'(pump_oe), 0);
    chk("R1 lock_det", int'(lock_det), 1);
    chk("R1 r_clr", int'(r_cnt_clr), 0);
    chk("R1 n_clr", int'(n_cnt_clr), 0);

    // R2: single reference edge sets pump_up on the next edge
    @(negedge clk); ref_pulse = 1'b1;
    @(negedge clk); ref_pulse = 1'b0;
    chk("R2 up set", int'(pump_up), 1);
    chk("R2 dn idle", int'(pump_dn), 0);
    div_pulse = 1'b1;
    @(negedge clk); div_pulse = 1'b0;
    chk("R2 dn set", int'(pump_dn), 1);
    repeat (MIN_W + 2) @(negedge clk);
    chk("R3 cleared", int'(pump_oe), 0);
    run_m = 0; // that comparison had skew 1

    // R3 R6 R7 sweep over signed separations, three rounds
    for (int r = 0; r < 3; r++)
      for (int d = -6; d <= 6; d++)
        compare(d < 0 ? -d : 0, -1, d > 0 ? d : 0);

    // R6: acquire lock with coincident edges, then lose and regain
    for (int k = 0; k < LOCK_CNT + 2; k++) compare(0, -1, 0);
    compare(0, -1, 1);
    compare(2, -1, 0);
    for (int k = 0; k < LOCK_CNT + 1; k++) compare(0, -1, 0);

    // R4: extra reference edges while pump_up is pending
    compare(0, 2, 5);
    compare(0, 3, 7);
    compare(1, 4, 6);

    // R8 R9: divider-reset request
    for (int k = 0; k < LOCK_CNT; k++) compare(0, -1, 0);
    cnt_rst_req = 1'b1;
    @(negedge clk);
    chk("R8 r_clr rise", int'(r_cnt_clr), 1);
    chk("R8 n_clr rise", int'(n_cnt_clr), 1);
    ref_pulse = 1'b1;
    @(negedge clk); ref_pulse = 1'b0;
    chk("R9 up held", int'(pump_up), 0);
    div_pulse = 1'b1;
    @(negedge clk); div_pulse = 1'b0;
    chk("R9 dn held", int'(pump_dn), 0);
    chk("R9 oe held", int'(pump_oe), 0);
    @(negedge clk);
    cnt_rst_req = 1'b0;
    chk("R8 r_clr still", int'(r_cnt_clr), 1);
    @(negedge clk);
    chk("R8 r_clr fall", int'(r_cnt_clr), 0);
    chk("R8 n_clr fall", int'(n_cnt_clr), 0);
    chk("R9 no late edge", int'(pump_oe), 0);
    run_m = 0; // R9 history cleared
    compare(0, -1, 0);
    compare(0, -1, 3);
    compare(0, -1, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule